// File: doc/BRIEF.md
# Next-PC and Branch Unit

This block works out, once per clock, the program counter that a 32-bit load/store RISC core fetches from next. Decode hands it the current PC, a small control-transfer code, the two register operands, the 16-bit branch displacement and the 26-bit jump field. The block registers the chosen address on the next rising edge and presents it on `nxt_pc`. It tests the two operands for equality itself, so the conditional branches need no help from the ALU.

Branch displacements are counted in instruction words. The block sign-extends the displacement, scales it by four and adds it to the address of the following instruction. Direct jumps keep the top four bits of that following address and replace the rest with the scaled 26-bit field. The register-indirect jump takes its target from the first operand. It flags the target, without changing it, when the address is not word aligned.

The link jump also raises a one-cycle write request for register 31, carrying the address of the following instruction. A less-than branch is built by software from a set-less-than instruction and a not-equal branch against register 0, so the block has no less-than compare.

Top module: `npc_unit`

## Requirements
- R1: While `rst_n` is low, `nxt_pc` equals parameter `RESET_PC` (default 0), and `link_we` and `jr_misalign` are 0.
- R2: Kind code 0 (sequential), and the unused codes 6 and 7, give `nxt_pc` = `cur_pc` + 4.
- R3: Kind code 1 (branch-if-equal) gives `cur_pc` + 4 + sign-extended `br_off` × 4 when `opnd_a` equals `opnd_b`, and otherwise `cur_pc` + 4.
- R4: Kind code 2 (branch-if-not-equal) takes the branch target when the operands differ, and otherwise gives `cur_pc` + 4.
- R5: The displacement reaches 32767 words forward (0x7FFF gives +131068 bytes) and 32768 words backward (0x8000 gives −131072 bytes), measured from `cur_pc` + 4.
- R6: Kind code 3 (jump) gives {(`cur_pc`+4)[31:28], `jmp_field`, 2'b00}. The region bits come from `cur_pc` + 4, not from `cur_pc`.
- R7: Kind code 4 (jump-and-link) gives the same target as R6. In the same output cycle it sets `link_we` = 1, `link_idx` = 31 and `link_val` = `cur_pc` + 4.
- R8: Kind code 5 (jump-register) gives `nxt_pc` = `opnd_a`.
- R9: `jr_misalign` is 1 only in the output cycle of a jump-register whose `opnd_a`[1:0] is not 0. Every other kind leaves it at 0.
- R10: Each output follows the inputs sampled at the previous rising edge, and changing the inputs between edges has no effect on the outputs.
- R11: `link_we` is 0 after every kind except jump-and-link, and a jump-and-link raises it for exactly one cycle.
- R12: PC arithmetic wraps modulo 2^32: `cur_pc` = 0xFFFFFFFC with kind 0 gives 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cur_pc | input | 32 | Address of the current instruction |
| xfer_kind | input | 3 | Control-transfer code: 0 seq, 1 beq, 2 bne, 3 j, 4 jal, 5 jr |
| opnd_a | input | 32 | First register operand (also the jr target) |
| opnd_b | input | 32 | Second register operand |
| br_off | input | 16 | Signed branch displacement in words |
| jmp_field | input | 26 | Direct jump target field |
| nxt_pc | output | 32 | Registered next program counter |
| link_we | output | 1 | One-cycle write request for the link register |
| link_idx | output | 5 | Register index for the link write (31) |
| link_val | output | 32 | Return address to write |
| jr_misalign | output | 1 | jr target not word aligned |

## Verification
The bench sweeps branch displacements across the whole 16-bit range with equal and unequal operands. This catches a design that scales by bytes instead of words, zero-extends the displacement, or swaps the sense of the two conditional branches. It drives the two extreme displacements and a jump from just below a 256 MB region boundary. A design that adds from `cur_pc` instead of `cur_pc` + 4, or takes the region bits from the wrong address, lands one word or one region off. Jump-register targets are driven with every value of the low two bits, to catch a flag tied to the wrong bits or raised by other kinds. Every cycle also checks the link request, so a write enable that lasts too long or fires on plain jumps shows up at once.

// File: rtl/npc_pkg.sv
`timescale 1ns/1ps
package npc_pkg;

  typedef enum logic [2:0] {
    XK_SEQ = 3'd0,
    XK_BEQ = 3'd1,
    XK_BNE = 3'd2,
    XK_J   = 3'd3,
    XK_JAL = 3'd4,
    XK_JR  = 3'd5
  } xfer_e;

  localparam int unsigned KIND_W = 3;

endpackage

// File: rtl/npc_addr_gen.sv
`timescale 1ns/1ps
module npc_addr_gen #(
  parameter int unsigned XLEN       = 32,
  parameter int unsigned OFF_W      = 16,
  parameter int unsigned TGT_W      = 26,
  parameter int unsigned INSN_BYTES = 4
) (
  input  logic [XLEN-1:0]  pc,
  input  logic [OFF_W-1:0] off,
  input  logic [TGT_W-1:0] field,
  output logic [XLEN-1:0]  pc_seq,
  output logic [XLEN-1:0]  br_tgt,
  output logic [XLEN-1:0]  jmp_tgt
);
  localparam int unsigned SHIFT    = $clog2(INSN_BYTES);
  localparam int unsigned REGION_W = XLEN - TGT_W - SHIFT;

  // Address of the instruction after pc.
  function automatic logic [XLEN-1:0] f_step(input logic [XLEN-1:0] p);
    return p + XLEN'(INSN_BYTES);
  endfunction

  // Word displacement -> byte displacement, sign preserved.
  function automatic logic [XLEN-1:0] f_scale_off(input logic [OFF_W-1:0] o);
    logic [XLEN-1:0] ext;
    ext = {{(XLEN-OFF_W){o[OFF_W-1]}}, o};
    return ext << SHIFT;
  endfunction

  // Region bits of the following address glued to the scaled field.
  function automatic logic [XLEN-1:0] f_region_jump(input logic [XLEN-1:0] nxt,
                                                    input logic [TGT_W-1:0] f);
    return {nxt[XLEN-1 -: REGION_W], f, {SHIFT{1'b0}}};
  endfunction

  always_comb begin
    pc_seq  = f_step(pc);
    br_tgt  = pc_seq + f_scale_off(off);
    jmp_tgt = f_region_jump(pc_seq, field);
  end

endmodule

// File: rtl/npc_cond.sv
`timescale 1ns/1ps
module npc_cond #(
  parameter int unsigned XLEN = 32
) (
  input  npc_pkg::xfer_e   kind,
  input  logic [XLEN-1:0]  a,
  input  logic [XLEN-1:0]  b,
  output logic             take_branch
);
  logic same;

  always_comb begin
    same = (a == b);
    case (kind)
      npc_pkg::XK_BEQ: take_branch = same;
      npc_pkg::XK_BNE: take_branch = !same;
      default:         take_branch = 1'b0;
    endcase
  end

endmodule

// File: rtl/npc_select.sv
`timescale 1ns/1ps
module npc_select #(
  parameter int unsigned XLEN       = 32,
  parameter int unsigned INSN_BYTES = 4
) (
  input  npc_pkg::xfer_e  kind,
  input  logic            take_branch,
  input  logic [XLEN-1:0] pc_seq,
  input  logic [XLEN-1:0] br_tgt,
  input  logic [XLEN-1:0] jmp_tgt,
  input  logic [XLEN-1:0] reg_tgt,
  output logic [XLEN-1:0] pc_next,
  output logic            link_req,
  output logic            misalign_req
);
  localparam int unsigned SHIFT = $clog2(INSN_BYTES);

  always_comb begin
    pc_next      = pc_seq;
    link_req     = 1'b0;
    misalign_req = 1'b0;
    case (kind)
      npc_pkg::XK_BEQ,
      npc_pkg::XK_BNE: if (take_branch) pc_next = br_tgt;
      npc_pkg::XK_J:   pc_next = jmp_tgt;
      npc_pkg::XK_JAL: begin
        pc_next  = jmp_tgt;
        link_req = 1'b1;
      end
      npc_pkg::XK_JR: begin
        pc_next      = reg_tgt;
        misalign_req = (reg_tgt[SHIFT-1:0] != '0);
      end
      default: pc_next = pc_seq;
    endcase
  end

endmodule

// File: rtl/npc_unit.sv
`timescale 1ns/1ps
module npc_unit #(
  parameter int unsigned XLEN       = 32,
  parameter int unsigned OFF_W      = 16,
  parameter int unsigned TGT_W      = 26,
  parameter int unsigned REG_AW     = 5,
  parameter int unsigned LINK_REG   = 31,
  parameter int unsigned INSN_BYTES = 4,
  parameter logic [XLEN-1:0] RESET_PC = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [XLEN-1:0]   cur_pc,
  input  logic [2:0]        xfer_kind,
  input  logic [XLEN-1:0]   opnd_a,
  input  logic [XLEN-1:0]   opnd_b,
  input  logic [OFF_W-1:0]  br_off,
  input  logic [TGT_W-1:0]  jmp_field,
  output logic [XLEN-1:0]   nxt_pc,
  output logic              link_we,
  output logic [REG_AW-1:0] link_idx,
  output logic [XLEN-1:0]   link_val,
  output logic              jr_misalign
);
  npc_pkg::xfer_e  kind;
  logic [XLEN-1:0] pc_seq, br_tgt, jmp_tgt, pc_next;
  logic            take_branch, link_req, misalign_req;

  assign kind     = npc_pkg::xfer_e'(xfer_kind);
  assign link_idx = REG_AW'(LINK_REG);

  npc_addr_gen #(
    .XLEN(XLEN), .OFF_W(OFF_W), .TGT_W(TGT_W), .INSN_BYTES(INSN_BYTES)
  ) u_addr (
    .pc(cur_pc), .off(br_off), .field(jmp_field),
    .pc_seq(pc_seq), .br_tgt(br_tgt), .jmp_tgt(jmp_tgt)
  );

  npc_cond #(.XLEN(XLEN)) u_cond (
    .kind(kind), .a(opnd_a), .b(opnd_b), .take_branch(take_branch)
  );

  npc_select #(.XLEN(XLEN), .INSN_BYTES(INSN_BYTES)) u_sel (
    .kind(kind), .take_branch(take_branch), .pc_seq(pc_seq),
    .br_tgt(br_tgt), .jmp_tgt(jmp_tgt), .reg_tgt(opnd_a),
    .pc_next(pc_next), .link_req(link_req), .misalign_req(misalign_req)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nxt_pc      <= RESET_PC;
      link_we     <= 1'b0;
      link_val    <= '0;
      jr_misalign <= 1'b0;
    end else begin
      nxt_pc      <= pc_next;
      link_we     <= link_req;
      jr_misalign <= misalign_req;
      if (link_req) link_val <= pc_seq;
    end
  end

endmodule

// File: rtl/npc_unit_chk.sv
`timescale 1ns/1ps
module npc_unit_chk #(
  parameter int unsigned XLEN   = 32,
  parameter int unsigned REG_AW = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2:0]        xfer_kind,
  input logic [XLEN-1:0]   cur_pc,
  input logic [XLEN-1:0]   opnd_a,
  input logic [XLEN-1:0]   opnd_b,
  input logic [XLEN-1:0]   nxt_pc,
  input logic              link_we,
  input logic [REG_AW-1:0] link_idx,
  input logic [XLEN-1:0]   link_val,
  input logic              jr_misalign,
  input logic              take_branch
);
  localparam logic [2:0] K_SEQ = 3'(npc_pkg::XK_SEQ);
  localparam logic [2:0] K_BEQ = 3'(npc_pkg::XK_BEQ);
  localparam logic [2:0] K_BNE = 3'(npc_pkg::XK_BNE);
  localparam logic [2:0] K_JAL = 3'(npc_pkg::XK_JAL);
  localparam logic [2:0] K_JR  = 3'(npc_pkg::XK_JR);

  assert_seq_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_kind == K_SEQ) |=> (nxt_pc == $past(cur_pc) + 32'd4));

  assert_beq_fallthru_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_kind == K_BEQ && opnd_a != opnd_b) |=> (nxt_pc == $past(cur_pc) + 32'd4));

  assert_bne_no_take_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_kind == K_BNE && opnd_a == opnd_b) |-> !take_branch);

  assert_jal_link_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_kind == K_JAL) |=> (link_we && link_idx == REG_AW'(31)
                              && link_val == $past(cur_pc) + 32'd4));

  assert_jr_target_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_kind == K_JR) |=> (nxt_pc == $past(opnd_a)));

  assert_misalign_only_jr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_kind != K_JR) |=> !jr_misalign);

  assert_link_only_jal_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_kind != K_JAL) |=> !link_we);

endmodule

bind npc_unit npc_unit_chk #(.XLEN(XLEN), .REG_AW(REG_AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .xfer_kind(xfer_kind), .cur_pc(cur_pc),
  .opnd_a(opnd_a), .opnd_b(opnd_b), .nxt_pc(nxt_pc), .link_we(link_we),
  .link_idx(link_idx), .link_val(link_val), .jr_misalign(jr_misalign),
  .take_branch(take_branch)
);

// File: tb/sim_npc_unit.sv
`timescale 1ns/1ps
module sim_npc_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] cur_pc = '0, opnd_a = '0, opnd_b = '0;
  logic [2:0]  xfer_kind = '0;
  logic [15:0] br_off = '0;
  logic [25:0] jmp_field = '0;
  logic [31:0] nxt_pc, link_val;
  logic        link_we, jr_misalign;
  logic [4:0]  link_idx;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  npc_unit u0 (
    .clk(clk), .rst_n(rst_n), .cur_pc(cur_pc), .xfer_kind(xfer_kind),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .br_off(br_off), .jmp_field(jmp_field),
    .nxt_pc(nxt_pc), .link_we(link_we), .link_idx(link_idx),
    .link_val(link_val), .jr_misalign(jr_misalign)
  );

  task automatic cmp(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h expected=%h", tag, got, exp);
    end
  endtask

  // Called at a falling edge: drive, let one rising edge pass, check at the next fall.
  task automatic step(input logic [2:0] k, input logic [31:0] pc, input logic [31:0] a,
                      input logic [31:0] b, input logic [15:0] off,
                      input logic [25:0] fld, input string tag);
    logic [31:0] after, want;
    int          disp;
    bit          want_we, want_mis;
    after    = pc + 32'd4;
    disp     = int'($signed(off)) * 4;
    want_we  = 0;
    want_mis = 0;
    case (k)
      3'd1: want = (a == b) ? after + 32'(disp) : after;
      3'd2: want = (a != b) ? after + 32'(disp) : after;
      3'd3: want = (after & 32'hF000_0000) | ({6'd0, fld} * 32'd4);
      3'd4: begin want = (after & 32'hF000_0000) | ({6'd0, fld} * 32'd4); want_we = 1; end
      3'd5: begin want = a; want_mis = (a % 4) != 0; end
      default: want = after;
    endcase
    xfer_kind = k; cur_pc = pc; opnd_a = a; opnd_b = b; br_off = off; jmp_field = fld;
    @(posedge clk);
    @(negedge clk);
    cmp({tag, " nxt_pc"}, nxt_pc, want);
    cmp({tag, " link_we R11"}, 32'(link_we), 32'(want_we));
    cmp({tag, " jr_misalign R9"}, 32'(jr_misalign), 32'(want_mis));
    if (want_we) begin
      cmp({tag, " link_val R7"}, link_val, after);
      cmp({tag, " link_idx R7"}, 32'(link_idx), 32'd31);
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    cmp("R1 reset nxt_pc", nxt_pc, 32'h0);
    cmp("R1 reset link_we", 32'(link_we), 32'd0);
    cmp("R1 reset jr_misalign", 32'(jr_misalign), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: sequential and unused codes
    step(3'd0, 32'h0000_1000, 0, 0, 16'h1234, 26'h1, "R2 seq");
    step(3'd6, 32'h0040_0020, 5, 5, 16'h0010, 26'h2, "R2 code6");
    step(3'd7, 32'h0040_0024, 1, 2, 16'hFFFF, 26'h3, "R2 code7");

    // R3/R4: displacement sweep, equal and unequal operands
    for (int i = 0; i < 256; i++) begin
      logic [15:0] o;
      o = 16'(i * 257 + 3);
      step(3'd1, 32'h0001_0000 + 32'(i * 8), 32'hA5A5_0000 + 32'(i), 32'hA5A5_0000 + 32'(i), o, 0, "R3 beq taken");
      step(3'd1, 32'h0001_0000 + 32'(i * 8), 32'(i), 32'(i) ^ 32'h8000_0000, o, 0, "R3 beq not taken");
      step(3'd2, 32'h0002_0000 + 32'(i * 4), 32'(i), 32'(i + 1), o, 0, "R4 bne taken");
      step(3'd2, 32'h0002_0000 + 32'(i * 4), 32'hFFFF_FFFF, 32'hFFFF_FFFF, o, 0, "R4 bne not taken");
    end

    // R5: extreme displacements
    step(3'd1, 32'h0010_0000, 7, 7, 16'h7FFF, 0, "R5 max forward");
    cmp("R5 forward literal", nxt_pc, 32'h0010_0004 + 32'd131068);
    step(3'd2, 32'h0010_0000, 7, 8, 16'h8000, 0, "R5 max backward");
    cmp("R5 backward literal", nxt_pc, 32'h0010_0004 - 32'd131072);

    // R6/R7: jump field sweep, one bit at a time, across regions
    for (int i = 0; i < 26; i++) begin
      step(3'd3, {4'(i), 28'h000_0100}, 0, 0, 0, 26'(1) << i, "R6 j");
      step(3'd4, {4'(15 - i % 16), 28'h123_4560}, 0, 0, 0, ~(26'(1) << i), "R7 jal");
    end
    // R6: region taken from pc+4 across a 256 MB boundary
    step(3'd3, 32'h0FFF_FFFC, 0, 0, 0, 26'h000_0040, "R6 region boundary");
    cmp("R6 region literal", nxt_pc, 32'h1000_0100);

    // R11: jal pulse lasts one cycle
    step(3'd4, 32'h0000_2000, 0, 0, 0, 26'h00_0800, "R7 jal before seq");
    step(3'd0, 32'h0000_2000, 0, 0, 0, 0, "R11 pulse ends");

    // R8/R9: jr targets, every low-bit pattern
    for (int i = 0; i < 16; i++)
      step(3'd5, 32'h0000_3000, 32'h8000_1000 + 32'(i * 1), 32'h0, 0, 0, "R8 jr");

    // R12: wrap
    step(3'd0, 32'hFFFF_FFFC, 0, 0, 0, 0, "R12 wrap");
    cmp("R12 wrap literal", nxt_pc, 32'h0);

    // R10: inputs changed between edges do not move outputs
    step(3'd0, 32'h0000_4000, 0, 0, 0, 0, "R10 base");
    xfer_kind = 3'd5; opnd_a = 32'h0000_0003;
    #1;
    cmp("R10 nxt_pc held", nxt_pc, 32'h0000_4004);
    cmp("R10 misalign held", 32'(jr_misalign), 32'd0);
    @(posedge clk);
    @(negedge clk);
    cmp("R10 after edge R8", nxt_pc, 32'h0000_0003);
    cmp("R10 after edge R9", 32'(jr_misalign), 32'd1);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule